// File: doc/BRIEF.md
# Cassette Controller Host Register Block

This block is the register face of a two-drive cassette tape controller as seen by a host processor. The host issues one of eight operations, selected by a 3-bit code, with an 8-bit data word. The block holds a control register and an error/state register, answers skip tests, returns read data in the same cycle, drives the interrupt request, and decides whether a GO operation may start a tape motion. The drive mechanics, the character data path and the checksum engine live elsewhere. They report to this block through level inputs (attached, write-protected, busy, at beginning of tape) and single-cycle event pulses (character ready, checksum fault, operation done with end-of-file or tape-edge qualifiers).

Cassettes mark files with gaps rather than recorded marks, so the block keeps a small per-drive memory of the last motion direction and of whether that motion ended inside a gap. When a new read or space operation runs the other way, the block tells the motion logic to pass over that gap first. A forward read or space started at beginning of tape is told to pass over the leading gap.

Top module: `cassette_host_regs`

## Requirements
- R1: After reset the control register is 0, the data flag is clear, the interrupt request is low and a status read returns 0.
- R2: Operation code 4 loads the control register from the data input and returns the bitwise complement of the data input on rd_data in the same cycle. Control fields: bit 7 enable, bit 6 drive select, bits 5:3 function, bit 0 interrupt enable.
- R3: Operation code 7 returns the low 8 bits of the status register while enable is set, and 0 while enable is clear. Status fields: 8 write-lock error, 7 checksum error, 6 timing error, 5 tape edge, 4 end of file, 3 empty, 2 rewinding, 1 write locked, 0 ready.
- R4: Skip is raised for code 1 when the data flag is set, for code 2 on any error, for code 3 when ready and not empty, for code 5 on data flag, any error or ready; every other code gives no skip.
- R5: "Any error" covers status bits 8, 7, 6, 5, 4 and 3, so a write-lock error that cannot be read still makes code 2 skip; with enable clear no error is seen.
- R6: The interrupt request equals control bit 0 AND (data flag OR any error OR ready), all taken from the enable-masked status.
- R7: Code 6 always clears the data flag; it starts an operation (start_go high for that cycle, function and drive from the control register) only when enable is set, the selected drive is attached and no drive is busy.
- R8: An accepted GO clears status bits 8, 7, 6, 4 and 2; a started motion also clears bit 5, and a started rewind (function 1) sets bit 2.
- R9: A write-type function (2 or 4) on a write-protected drive sets status bit 8 and does not start.
- R10: Status bit 1 reads set while the shown drive is write-protected or rewinding; a drive that is not attached reads bits 3 and 1 set; bit 0 reads set while no drive is busy. The shown drive is the active one while busy, otherwise the selected one.
- R11: A done pulse sets bit 4 when flagged end-of-file, sets bit 5 when flagged tape edge or when the active function is rewind, and clears bit 2.
- R12: A started read (0) or space-forward (7) on a drive at beginning of tape raises skip_lead_gap with start_go.
- R13: A started read or space function (0, 3, 5, 6, 7) raises skip_rev_gap when that drive's previous operation ended with end-of-file and the new direction (reverse for 3 and 5) differs from the previous one; any started operation clears the drive's gap memory, and each drive keeps its own.
- R14: A character-ready pulse sets the data flag and, if the flag was already set, status bit 6; code 0 clears the control register, the status register, the data flag and all gap memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Host operation present this cycle |
| op_code | input | 3 | Operation select |
| op_wdata | input | 8 | Host data word |
| rd_data | output | 8 | Data returned for the operation |
| skip | output | 1 | Skip condition for the operation |
| irq | output | 1 | Interrupt request |
| drv_attached | input | 2 | Per-drive cassette present |
| drv_wprot | input | 2 | Per-drive write protect |
| drv_busy | input | 2 | Per-drive motion in progress |
| drv_at_bot | input | 2 | Per-drive at beginning of tape |
| data_ready | input | 1 | Character transfer pulse from data path |
| crc_fault | input | 1 | Checksum fault pulse |
| done_valid | input | 1 | Active operation finished |
| done_eof | input | 1 | Finished inside a file gap |
| done_edge | input | 1 | Finished at tape edge |
| start_go | output | 1 | Start the selected operation |
| start_func | output | 3 | Function to start |
| start_unit | output | 1 | Drive to start |
| skip_lead_gap | output | 1 | Pass over leading gap before the operation |
| skip_rev_gap | output | 1 | Pass over the gap left by the previous operation |

## Verification
Directed sequences walk an empty drive, a protected drive, a blocked write, a rewind with its busy phase and completion, a forward read at beginning of tape and a space-forward ending in a gap followed by a reverse space, which separate the start gating, the clear-on-start rules and the gap memory from one another. A second drive carries its own gap history so cross-drive leakage shows up as a wrong skip_rev_gap. Random operation streams with random drive levels and event pulses then compare every returned word, skip, interrupt and start output against a bench model, which catches enable masking and skip-condition mix-ups that the directed cases do not reach.

// File: rtl/cas_pkg.sv
// Shared constants, field positions and function-code helpers for the
// cassette host register block. Assumes 8-bit control and 9-bit status.
package cas_pkg;
    localparam int NUM_DRV = 2;
    localparam int CTL_W   = 8;
    localparam int STAT_W  = 9;
    localparam int FN_W    = 3;

    // host operation codes
    localparam logic [2:0] OP_CLEAR    = 3'd0;
    localparam logic [2:0] OP_SKIP_DF  = 3'd1;
    localparam logic [2:0] OP_SKIP_ERR = 3'd2;
    localparam logic [2:0] OP_SKIP_RDY = 3'd3;
    localparam logic [2:0] OP_LOAD_A   = 3'd4;
    localparam logic [2:0] OP_SKIP_ANY = 3'd5;
    localparam logic [2:0] OP_GO       = 3'd6;
    localparam logic [2:0] OP_READ_B   = 3'd7;

    // tape function codes
    localparam logic [2:0] FN_READ     = 3'd0;
    localparam logic [2:0] FN_REWIND   = 3'd1;
    localparam logic [2:0] FN_WRITE    = 3'd2;
    localparam logic [2:0] FN_SP_RFILE = 3'd3;
    localparam logic [2:0] FN_WR_GAP   = 3'd4;
    localparam logic [2:0] FN_SP_RBLK  = 3'd5;
    localparam logic [2:0] FN_CRC      = 3'd6;
    localparam logic [2:0] FN_SP_FFILE = 3'd7;

    // control register fields
    localparam int A_EN    = 7;
    localparam int A_UNIT  = 6;
    localparam int A_FN_LO = 3;
    localparam int A_IE    = 0;

    // status register fields
    localparam int B_WLE  = 8;
    localparam int B_CRC  = 7;
    localparam int B_TIM  = 6;
    localparam int B_EDGE = 5;
    localparam int B_EOF  = 4;
    localparam int B_EMP  = 3;
    localparam int B_REW  = 2;
    localparam int B_WLK  = 1;
    localparam int B_RDY  = 0;

    // stored (non-derived) status bits
    typedef struct packed {
        logic wle;
        logic crc;
        logic tim;
        logic edge_hit;
        logic eof;
        logic rew;
    } stat_store_t;

    function automatic logic fn_is_write(input logic [2:0] f);
        return (f == FN_WRITE) || (f == FN_WR_GAP);
    endfunction

    function automatic logic fn_is_rev(input logic [2:0] f);
        return (f == FN_SP_RFILE) || (f == FN_SP_RBLK);
    endfunction

    function automatic logic fn_is_fwd(input logic [2:0] f);
        return (f == FN_READ) || (f == FN_WRITE) || (f == FN_WR_GAP) || (f == FN_SP_FFILE);
    endfunction

    // read or space: functions that consult gap memory
    function automatic logic fn_is_scan(input logic [2:0] f);
        return (f != FN_REWIND) && !fn_is_write(f);
    endfunction
endpackage

// File: rtl/cas_gap_track.sv
// Per-drive direction and gap memory. Decides, at the moment an operation
// starts, whether the motion logic must first pass over the leading gap
// (forward scan at beginning of tape) or over a gap the previous operation
// stopped in (scan in the opposite direction). Assumes go is already gated.
module cas_gap_track
    import cas_pkg::*;
#(
    parameter int NDRV = NUM_DRV,
    localparam int UW  = (NDRV > 1) ? $clog2(NDRV) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            go,
    input  logic [UW-1:0]   go_unit,
    input  logic [FN_W-1:0] go_fn,
    input  logic [NDRV-1:0] at_bot,
    input  logic            done,
    input  logic            done_eof,
    input  logic [UW-1:0]   done_unit,
    output logic            skip_lead,
    output logic            skip_rev
);
    logic [NDRV-1:0] gap_q;
    logic [NDRV-1:0] rev_q;
    logic            scan;
    logic            new_rev;

    // classify the function being started
    always_comb begin
        scan    = fn_is_scan(go_fn);
        new_rev = fn_is_rev(go_fn);
    end

    // leading-gap request has priority over the reversal request
    always_comb begin
        skip_lead = go && scan && fn_is_fwd(go_fn) && at_bot[go_unit];
        skip_rev  = go && scan && !skip_lead && gap_q[go_unit] && (rev_q[go_unit] != new_rev);
    end

    for (genvar g = 0; g < NDRV; g++) begin : g_drv
        // hold direction of the last start and whether it ended in a gap
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                gap_q[g] <= 1'b0;
                rev_q[g] <= 1'b0;
            end else if (go && (go_unit == UW'(g))) begin
                gap_q[g] <= 1'b0;
                rev_q[g] <= scan ? new_rev : 1'b0;
            end else if (done && done_eof && (done_unit == UW'(g))) begin
                gap_q[g] <= 1'b1;
            end
        end

        p_gap_set_r13: assert property (@(posedge clk) disable iff (!rst_n)
            (done && done_eof && (done_unit == UW'(g)) && !clr && !(go && (go_unit == UW'(g))))
            |=> gap_q[g]);
        p_gap_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
            (go && (go_unit == UW'(g))) |=> !gap_q[g]);
        p_rev_dir_r13: assert property (@(posedge clk) disable iff (!rst_n)
            (go && (go_unit == UW'(g)) && !clr && new_rev) |=> rev_q[g]);
    end
endmodule

// File: rtl/cas_status_b.sv
// Status register: stored error and state bits plus the bits derived each
// cycle from the shown drive. Assumes start_try is GO accepted by enable,
// attachment and idle checks, and wr_block marks a refused write.
module cas_status_b
    import cas_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              start_try,
    input  logic              wr_block,
    input  logic [FN_W-1:0]   start_fn,
    input  logic              data_ready,
    input  logic              df_q,
    input  logic              crc_fault,
    input  logic              done,
    input  logic              done_eof,
    input  logic              done_edge,
    input  logic              done_rewind,
    input  logic              sel_att,
    input  logic              sel_wp,
    input  logic              busy_any,
    output logic [STAT_W-1:0] stat_o
);
    stat_store_t st_q, st_d;
    logic        emp, rew_show, wlk, rdy;

    // next value of the stored bits: clear on start, then set on events
    always_comb begin
        st_d = st_q;
        if (start_try) begin
            st_d.wle = 1'b0;
            st_d.crc = 1'b0;
            st_d.tim = 1'b0;
            st_d.eof = 1'b0;
            st_d.rew = 1'b0;
            if (wr_block) begin
                st_d.wle = 1'b1;
            end else begin
                st_d.edge_hit = 1'b0;
                if (start_fn == FN_REWIND) st_d.rew = 1'b1;
            end
        end
        if (data_ready && df_q) st_d.tim = 1'b1;
        if (crc_fault)          st_d.crc = 1'b1;
        if (done) begin
            if (done_eof)                 st_d.eof      = 1'b1;
            if (done_edge || done_rewind) st_d.edge_hit = 1'b1;
            st_d.rew = 1'b0;
        end
    end

    // register the stored bits
    always_ff @(posedge clk) begin
        if (!rst_n || clr) st_q <= '0;
        else               st_q <= st_d;
    end

    // derive the drive-dependent bits and pack the register
    always_comb begin
        emp      = !sel_att;
        rew_show = st_q.rew && sel_att;
        wlk      = sel_wp || rew_show || emp;
        rdy      = !busy_any;
        stat_o   = {st_q.wle, st_q.crc, st_q.tim, st_q.edge_hit, st_q.eof,
                    emp, rew_show, wlk, rdy};
    end

    p_wle_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_try && wr_block && !clr) |=> stat_o[B_WLE]);
    p_rew_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_try && !wr_block && (start_fn == FN_REWIND) && !clr && !done) |=> st_q.rew);
    p_edge_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_try && !wr_block && !clr && !done) |=> !stat_o[B_EDGE]);
    p_eof_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_eof && !clr) |=> stat_o[B_EOF]);
    p_tim_overrun_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && df_q && !clr) |=> stat_o[B_TIM]);
endmodule

// File: rtl/cassette_host_regs.sv
// Host-facing register block of a two-drive cassette controller. Decodes the
// eight host operations, holds the control register and data flag, masks the
// status register by enable, forms skips and the interrupt, and gates GO.
// Assumes drive levels are synchronous and event pulses last one cycle.
module cassette_host_regs
    import cas_pkg::*;
#(
    parameter int NDRV = NUM_DRV,
    localparam int UW  = (NDRV > 1) ? $clog2(NDRV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [2:0]       op_code,
    input  logic [CTL_W-1:0] op_wdata,
    output logic [CTL_W-1:0] rd_data,
    output logic             skip,
    output logic             irq,
    input  logic [NDRV-1:0]  drv_attached,
    input  logic [NDRV-1:0]  drv_wprot,
    input  logic [NDRV-1:0]  drv_busy,
    input  logic [NDRV-1:0]  drv_at_bot,
    input  logic             data_ready,
    input  logic             crc_fault,
    input  logic             done_valid,
    input  logic             done_eof,
    input  logic             done_edge,
    output logic             start_go,
    output logic [FN_W-1:0]  start_func,
    output logic [UW-1:0]    start_unit,
    output logic             skip_lead_gap,
    output logic             skip_rev_gap
);
    logic [CTL_W-1:0]  a_q;
    logic              df_q;
    logic [UW-1:0]     act_unit_q;
    logic [FN_W-1:0]   act_fn_q;
    logic              en, busy_any, clr, go, start_try, wr_block;
    logic [UW-1:0]     sel_unit, show_unit;
    logic [FN_W-1:0]   sel_fn;
    logic [STAT_W-1:0] stat_full, vis_b;
    logic              any_err, rdy, emp;

    // decode control fields and the operation strobes
    always_comb begin
        en        = a_q[A_EN];
        sel_unit  = a_q[A_UNIT +: UW];
        sel_fn    = a_q[A_FN_LO +: FN_W];
        busy_any  = |drv_busy;
        show_unit = busy_any ? act_unit_q : sel_unit;
        clr       = op_valid && (op_code == OP_CLEAR);
        go        = op_valid && (op_code == OP_GO);
        start_try = go && !busy_any && en && drv_attached[sel_unit];
        wr_block  = fn_is_write(sel_fn) && drv_wprot[sel_unit];
        start_go  = start_try && !wr_block;
        start_func = sel_fn;
        start_unit = sel_unit;
    end

    // control register: cleared by code 0, loaded by code 4
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                         a_q <= '0;
        else if (op_valid && op_code == OP_LOAD_A) a_q <= op_wdata;
    end

    // data flag: set by a character event, cleared by GO or code 0
    always_ff @(posedge clk) begin
        if (!rst_n || clr)   df_q <= 1'b0;
        else if (data_ready) df_q <= 1'b1;
        else if (go)         df_q <= 1'b0;
    end

    // remember which drive and function are in motion
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            act_unit_q <= '0;
            act_fn_q   <= '0;
        end else if (start_go) begin
            act_unit_q <= sel_unit;
            act_fn_q   <= sel_fn;
        end
    end

    cas_status_b u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .start_try   (start_try),
        .wr_block    (wr_block),
        .start_fn    (sel_fn),
        .data_ready  (data_ready),
        .df_q        (df_q),
        .crc_fault   (crc_fault),
        .done        (done_valid),
        .done_eof    (done_eof),
        .done_edge   (done_edge),
        .done_rewind (done_valid && (act_fn_q == FN_REWIND)),
        .sel_att     (drv_attached[show_unit]),
        .sel_wp      (drv_wprot[show_unit]),
        .busy_any    (busy_any),
        .stat_o      (stat_full)
    );

    cas_gap_track #(.NDRV(NDRV)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .go        (start_go),
        .go_unit   (sel_unit),
        .go_fn     (sel_fn),
        .at_bot    (drv_at_bot),
        .done      (done_valid),
        .done_eof  (done_eof),
        .done_unit (act_unit_q),
        .skip_lead (skip_lead_gap),
        .skip_rev  (skip_rev_gap)
    );

    // enable masking and the condition terms used by skips and interrupt
    always_comb begin
        vis_b   = en ? stat_full : '0;
        any_err = vis_b[B_WLE] | vis_b[B_CRC] | vis_b[B_TIM] |
                  vis_b[B_EDGE] | vis_b[B_EOF] | vis_b[B_EMP];
        rdy     = vis_b[B_RDY];
        emp     = vis_b[B_EMP];
        irq     = a_q[A_IE] && (df_q || any_err || rdy);
    end

    // same-cycle response to the host operation
    always_comb begin
        rd_data = '0;
        skip    = 1'b0;
        if (op_valid) begin
            case (op_code)
                OP_SKIP_DF:  skip    = df_q;
                OP_SKIP_ERR: skip    = any_err;
                OP_SKIP_RDY: skip    = rdy && !emp;
                OP_LOAD_A:   rd_data = ~op_wdata;
                OP_SKIP_ANY: skip    = df_q || any_err || rdy;
                OP_READ_B:   rd_data = vis_b[CTL_W-1:0];
                default:     ;
            endcase
        end
    end

    p_load_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_LOAD_A) |=> (a_q == $past(op_wdata)));
    p_irq_ie_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> a_q[A_IE]);
    p_df_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !data_ready) |=> !df_q);
    p_clear_r14: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((a_q == '0) && !df_q && (stat_full[B_WLE:B_EOF] == '0)));
    p_start_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_go |-> (!busy_any && !skip && (rd_data == '0)));
endmodule

// File: tb/cassette_host_regs_tb_top.sv
module cassette_host_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [2:0] op_code = '0;
    logic [7:0] op_wdata = '0;
    logic [7:0] rd_data;
    logic       skip, irq;
    logic [1:0] drv_attached = '0, drv_wprot = '0, drv_busy = '0, drv_at_bot = '0;
    logic       data_ready = 1'b0, crc_fault = 1'b0;
    logic       done_valid = 1'b0, done_eof = 1'b0, done_edge = 1'b0;
    logic       start_go;
    logic [2:0] start_func;
    logic [0:0] start_unit;
    logic       skip_lead_gap, skip_rev_gap;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    // bench model state
    logic [7:0] m_a;
    logic       m_wle, m_crc, m_tim, m_edge, m_eof, m_rew, m_df;
    logic [1:0] m_gap, m_rev;
    logic       m_act;
    logic [2:0] m_actfn;

    always #5 clk = ~clk;

    cassette_host_regs dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_wdata(op_wdata), .rd_data(rd_data), .skip(skip), .irq(irq),
        .drv_attached(drv_attached), .drv_wprot(drv_wprot), .drv_busy(drv_busy),
        .drv_at_bot(drv_at_bot), .data_ready(data_ready), .crc_fault(crc_fault),
        .done_valid(done_valid), .done_eof(done_eof), .done_edge(done_edge),
        .start_go(start_go), .start_func(start_func), .start_unit(start_unit),
        .skip_lead_gap(skip_lead_gap), .skip_rev_gap(skip_rev_gap)
    );

    function automatic logic f_wr(input logic [2:0] f); return f == 3'd2 || f == 3'd4; endfunction
    function automatic logic f_rv(input logic [2:0] f); return f == 3'd3 || f == 3'd5; endfunction
    function automatic logic f_fw(input logic [2:0] f);
        return f == 3'd0 || f == 3'd2 || f == 3'd4 || f == 3'd7;
    endfunction
    function automatic logic f_scan(input logic [2:0] f); return f != 3'd1 && !f_wr(f); endfunction

    function automatic logic [8:0] exp_vis();
        logic su, emp, rw, wlk;
        su  = (|drv_busy) ? m_act : m_a[6];
        emp = !drv_attached[su];
        rw  = m_rew && drv_attached[su];
        wlk = drv_wprot[su] || rw || emp;
        if (!m_a[7]) return 9'd0;
        return {m_wle, m_crc, m_tim, m_edge, m_eof, emp, rw, wlk, !(|drv_busy)};
    endfunction

    function automatic logic exp_err();
        logic [8:0] b;
        b = exp_vis();
        return b[8] | b[7] | b[6] | b[5] | b[4] | b[3];
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        m_a = '0; m_wle = 0; m_crc = 0; m_tim = 0; m_edge = 0; m_eof = 0; m_rew = 0;
        m_df = 0; m_gap = '0; m_rev = '0; m_act = 0; m_actfn = '0;
    endtask

    task automatic model_update();
        logic u; logic [2:0] f; logic ok, tr;
        u = m_a[6]; f = m_a[5:3];
        if (op_valid && op_code == 3'd0) begin
            model_clear();
            return;
        end
        tr = op_valid && op_code == 3'd6 && !(|drv_busy) && m_a[7] && drv_attached[u];
        ok = tr && !(f_wr(f) && drv_wprot[u]);
        if (data_ready && m_df) m_tim = 1;
        if (tr) begin
            m_wle = 0; m_crc = 0; m_tim = 0; m_eof = 0; m_rew = 0;
            if (!ok) m_wle = 1;
            else begin
                m_edge = 0;
                if (f == 3'd1) m_rew = 1;
                m_gap[u] = 0;
                m_rev[u] = f_scan(f) ? f_rv(f) : 1'b0;
            end
        end
        if (data_ready && m_df) m_tim = 1;
        if (crc_fault) m_crc = 1;
        if (done_valid) begin
            if (done_eof) begin m_eof = 1; if (!(ok && u == m_act)) m_gap[m_act] = 1; end
            if (done_edge || m_actfn == 3'd1) m_edge = 1;
            m_rew = 0;
        end
        if (op_valid && op_code == 3'd6) m_df = 0;
        if (data_ready) m_df = 1;
        if (ok) begin m_act = u; m_actfn = f; end
        if (op_valid && op_code == 3'd4) m_a = op_wdata;
    endtask

    // one host cycle: drive at negedge, check before posedge, update model at posedge
    task automatic step(input logic v, input logic [2:0] c, input logic [7:0] d, input string tag);
        logic u; logic [2:0] f; logic ok, lead, revs; logic [7:0] erd; logic esk; logic [8:0] b;
        @(negedge clk);
        op_valid = v; op_code = c; op_wdata = d;
        #2;
        u = m_a[6]; f = m_a[5:3]; b = exp_vis();
        ok = v && c == 3'd6 && !(|drv_busy) && m_a[7] && drv_attached[u] && !(f_wr(f) && drv_wprot[u]);
        lead = ok && f_scan(f) && f_fw(f) && drv_at_bot[u];
        revs = ok && f_scan(f) && !lead && m_gap[u] && (m_rev[u] != f_rv(f));
        erd = 8'd0; esk = 1'b0;
        if (v) begin
            case (c)
                3'd1: esk = m_df;
                3'd2: esk = exp_err();
                3'd3: esk = b[0] && !b[3];
                3'd4: erd = ~d;
                3'd5: esk = m_df || exp_err() || b[0];
                3'd7: erd = b[7:0];
                default: ;
            endcase
        end
        chk(tag, "rd_data", int'(rd_data), int'(erd));
        chk(tag, "skip", int'(skip), int'(esk));
        chk(tag, "irq", int'(irq), int'(m_a[0] && (m_df || exp_err() || b[0])));
        chk(tag, "start_go", int'(start_go), int'(ok));
        if (ok) chk(tag, "start_func/unit", int'({start_func, start_unit}), int'({f, u}));
        chk(tag, "skip_lead_gap", int'(skip_lead_gap), int'(lead));
        chk(tag, "skip_rev_gap", int'(skip_rev_gap), int'(revs));
        @(posedge clk);
        model_update();
        #1;
        op_valid = 0; data_ready = 0; crc_fault = 0; done_valid = 0; done_eof = 0; done_edge = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_clear();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        step(1, 3'd7, 8'h00, "R1");
        chk("R1", "rd_data after reset", int'(rd_data), 0);
        drv_attached = 2'b11;
        // R2: load control register, complement returned
        step(1, 3'd4, 8'h81, "R2");
        // R3 / R6: enabled status read, ready visible, interrupt raised
        step(1, 3'd7, 8'h00, "R3");
        step(1, 3'd4, 8'h01, "R6");
        step(1, 3'd7, 8'h00, "R3");
        step(1, 3'd5, 8'h00, "R6");
        // R10: empty drive reports empty and locked, error skip
        drv_attached = 2'b10;
        step(1, 3'd4, 8'h80, "R10");
        step(1, 3'd7, 8'h00, "R10");
        step(1, 3'd2, 8'h00, "R5");
        step(1, 3'd3, 8'h00, "R4");
        step(1, 3'd6, 8'h00, "R7");
        // R9 / R5: write on protected drive refused, hidden error still skips
        drv_attached = 2'b11; drv_wprot = 2'b01;
        step(1, 3'd7, 8'h00, "R10");
        step(1, 3'd4, 8'h90, "R9");
        step(1, 3'd6, 8'h00, "R9");
        step(1, 3'd7, 8'h00, "R9");
        step(1, 3'd2, 8'h00, "R5");
        // R8 / R11: rewind drive 1, busy phase, completion
        drv_wprot = 2'b00;
        step(1, 3'd4, 8'hC8, "R8");
        step(1, 3'd6, 8'h00, "R8");
        drv_busy = 2'b10;
        step(1, 3'd7, 8'h00, "R8");
        step(1, 3'd6, 8'h00, "R7");
        step(1, 3'd5, 8'h00, "R4");
        done_valid = 1;
        step(0, 3'd0, 8'h00, "R11");
        drv_busy = 2'b00;
        step(1, 3'd7, 8'h00, "R11");
        // R12: forward read at beginning of tape on drive 1
        drv_at_bot = 2'b10;
        step(1, 3'd4, 8'hC0, "R12");
        step(1, 3'd6, 8'h00, "R12");
        step(1, 3'd7, 8'h00, "R8");
        drv_at_bot = 2'b00;
        // R13: space forward file on drive 0 ends in gap, reverse skips it
        step(1, 3'd4, 8'hB8, "R13");
        step(1, 3'd6, 8'h00, "R13");
        done_valid = 1; done_eof = 1;
        step(0, 3'd0, 8'h00, "R11");
        step(1, 3'd7, 8'h00, "R11");
        step(1, 3'd4, 8'hE8, "R13");
        step(1, 3'd6, 8'h00, "R13");
        step(1, 3'd4, 8'hA8, "R13");
        step(1, 3'd6, 8'h00, "R13");
        done_valid = 1;
        step(0, 3'd0, 8'h00, "R13");
        step(1, 3'd4, 8'h90, "R13");
        step(1, 3'd6, 8'h00, "R13");
        step(1, 3'd4, 8'h80, "R13");
        step(1, 3'd6, 8'h00, "R13");
        // R14: data flag, timing error, checksum error, clear operation
        data_ready = 1;
        step(1, 3'd1, 8'h00, "R14");
        step(1, 3'd1, 8'h00, "R14");
        data_ready = 1;
        step(1, 3'd7, 8'h00, "R14");
        crc_fault = 1;
        step(1, 3'd7, 8'h00, "R4");
        step(1, 3'd7, 8'h00, "R4");
        step(1, 3'd0, 8'h00, "R14");
        step(1, 3'd7, 8'h00, "R14");
        step(1, 3'd4, 8'h81, "R14");
        step(1, 3'd7, 8'h00, "R14");
        step(1, 3'd1, 8'h00, "R14");
        // R7: busy drive blocks a start
        drv_busy = 2'b01;
        step(1, 3'd6, 8'h00, "R7");
        drv_busy = 2'b00;
        // random operation stream
        for (int i = 0; i < 800; i++) begin
            logic [2:0] c;
            if (i % 16 == 0) begin
                drv_attached = 2'($urandom); drv_wprot = 2'($urandom); drv_at_bot = 2'($urandom);
            end
            c = 3'($urandom);
            if (c == 3'd0 && ($urandom % 8) != 0) c = 3'd5;
            if (c != 3'd0 && c != 3'd6) begin
                data_ready = ($urandom % 4) == 0;
                crc_fault  = ($urandom % 16) == 0;
                if (($urandom % 6) == 0) begin
                    done_valid = 1; done_eof = 1'($urandom); done_edge = 1'($urandom);
                end
            end
            step(1, c, 8'($urandom) | 8'h80 & 8'($urandom), "R4");
        end
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule